// File: doc/BRIEF.md
# Pixel to Bus-Word Packer

This block sits between a pixel source and a narrow parallel display bus. It takes pixels of 12, 16, 18 or 24 bits and cuts each one into bus words for a data bus that is 8, 9, 12 or 16 lines wide. The number of bus words per pixel follows from the ratio of pixel width to bus width. It can be one, two or three words per pixel. It can also be three words per two pixels, where the middle word is made of half a bus width from each pixel of the pair. Each outgoing word carries a flag that marks it as command (0) or data (1).

Software first loads a pixel total and pulses a start input. The block then accepts exactly that many pixels on a valid/ready stream and emits their bus words on a valid/ready output. When the last word of the last pixel leaves, the block clears its busy state and raises a one-cycle frame-done pulse.

While no frame is running, command and parameter writes pass straight through to the output without packing. The block checks the configured combination of pixel width and bus width. If the combination is invalid, it raises a config-error flag and refuses pixels until the configuration is corrected.

Top module: `pix_bus_packer`

## Requirements
- R1: While reset is asserted and right after it, `out_valid`, `pix_ready`, `busy` and `frame_done` are 0.
- R2: The pixel width codes are 0=12, 1=16, 2=18 and 3=24 bits. The bus width codes are 0=8, 1=9, 2=12 and 3=16 lines. If the pixel width is a multiple of 1, 2 or 3 bus widths, the format has that many words per pixel. Otherwise, if twice the pixel width is exactly three bus widths, the format is three words per two pixels. Every other pair sets `cfg_err`, and no pixel is accepted while `cfg_err` is 1.
- R3: In the one-word format, a pixel appears on the low bus lines of `out_data`, with `out_dc`=1. Lines above the bus width are 0, and pixel input bits above the pixel width are ignored.
- R4: In the two- and three-word formats, the pixel is sent most significant chunk first. For example, a 24-bit pixel on 8 lines goes out as bits [23:16], then [15:8], then [7:0].
- R5: In the three-words-per-two-pixels format, the words are the MSB-first bit stream of the first pixel followed by the second pixel, cut into bus-width chunks. So the middle word holds the low half-width of the first pixel above the top half-width of the second.
- R6: In that paired format, if the frame total is odd, the last pixel is paired with an all-zero pixel, so three words still go out.
- R7: After `frame_total` pixels have been accepted and their last word has been handed off, `busy` falls and `frame_done` is 1 for exactly one cycle. The block then accepts no further pixels.
- R8: While not busy, a write on `wr_*` goes straight to the output with `out_dc` equal to `wr_flag`, where 0 means command and 1 means parameter. While busy, `wr_ready` is 0 and writes do not reach the output.
- R9: While an output word is offered and `out_ready` is 0, `out_valid`, `out_data` and `out_dc` stay unchanged.
- R10: A start pulse with a total of 0 is ignored. A start pulse during a frame is ignored. The total is captured at start, so later changes to `frame_total` do not affect the running frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_dtype | input | 2 | Pixel width code |
| cfg_bus | input | 2 | Bus width code |
| frame_total | input | CNT_W | Number of pixels in the next frame |
| frame_start | input | 1 | Starts a frame when idle |
| pix_valid | input | 1 | Pixel offered |
| pix_data | input | 24 | Pixel, right-aligned |
| pix_ready | output | 1 | Pixel accepted this cycle when valid |
| wr_valid | input | 1 | Command/parameter write offered |
| wr_flag | input | 1 | 0 command, 1 parameter |
| wr_data | input | 16 | Write word |
| wr_ready | output | 1 | Write accepted this cycle when valid |
| out_valid | output | 1 | Bus word offered |
| out_data | output | 16 | Bus word, right-aligned to bus width |
| out_dc | output | 1 | 0 command, 1 data |
| out_ready | input | 1 | Downstream takes the word |
| cfg_err | output | 1 | Width combination invalid |
| busy | output | 1 | Frame in progress |
| frame_done | output | 1 | One-cycle end-of-frame pulse |

## Verification
Every valid pairing of pixel width and bus width is run with random pixel values and random junk above the pixel width. Downstream readiness is set to full, partial and sparse. This separates errors in chunk order from errors in masking and in backpressure handling. Odd and even frame totals in the paired format show whether the zero padding and the middle split are right. A single-pixel frame held under backpressure shows word stability. Invalid widths, start pulses with a total of zero or in mid-frame, and writes attempted during a frame each check one rule about what must have no effect.

// File: rtl/pix_bus_packer.sv
module pix_bus_packer #(
  parameter int CNT_W = 22
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       cfg_dtype,
  input  logic [1:0]       cfg_bus,
  input  logic [CNT_W-1:0] frame_total,
  input  logic             frame_start,
  input  logic             pix_valid,
  input  logic [23:0]      pix_data,
  output logic             pix_ready,
  input  logic             wr_valid,
  input  logic             wr_flag,
  input  logic [15:0]      wr_data,
  output logic             wr_ready,
  output logic             out_valid,
  output logic [15:0]      out_data,
  output logic             out_dc,
  input  logic             out_ready,
  output logic             cfg_err,
  output logic             busy,
  output logic             frame_done
);

  logic [1:0]       fmt;
  logic             fmt_ok;
  logic [4:0]       pw, bw, hw, sh;
  logic [23:0]      mb, mh;
  logic [1:0]       last_step;

  logic             run, have, have_b, tail, done_q;
  logic [1:0]       step;
  logic [23:0]      a_q, b_q;
  logic [CNT_W-1:0] cnt, tot_q;
  logic [15:0]      pk_word;
  logic             pk_valid, pix_go, pk_go, hits;

  always_comb begin
    fmt    = 2'd0;
    fmt_ok = 1'b1;
    case ({cfg_dtype, cfg_bus})
      4'b00_00: fmt = 2'd3;
      4'b00_10: fmt = 2'd0;
      4'b01_00: fmt = 2'd1;
      4'b01_11: fmt = 2'd0;
      4'b10_01: fmt = 2'd1;
      4'b10_10: fmt = 2'd3;
      4'b11_00: fmt = 2'd2;
      4'b11_10: fmt = 2'd1;
      4'b11_11: fmt = 2'd3;
      default:  fmt_ok = 1'b0;
    endcase
  end

  assign pw = (cfg_dtype == 2'd0) ? 5'd12 : (cfg_dtype == 2'd1) ? 5'd16 :
              (cfg_dtype == 2'd2) ? 5'd18 : 5'd24;
  assign bw = (cfg_bus == 2'd0) ? 5'd8 : (cfg_bus == 2'd1) ? 5'd9 :
              (cfg_bus == 2'd2) ? 5'd12 : 5'd16;
  assign hw = {1'b0, bw[4:1]};
  assign mb = ~(24'hFF_FFFF << bw);
  assign mh = ~(24'hFF_FFFF << hw);
  assign last_step = (fmt == 2'd3) ? 2'd2 : fmt;

  always_comb begin
    sh = pw - bw;
    if (step == 2'd1)      sh = pw - bw - bw;
    else if (step == 2'd2) sh = pw - bw - bw - bw;
    if (fmt == 2'd3 && step == 2'd1)
      pk_word = 16'(((a_q & mh) << hw) | ((b_q >> (pw - hw)) & mh));
    else if (fmt == 2'd3 && step == 2'd2)
      pk_word = 16'(b_q & mb);
    else
      pk_word = 16'((a_q >> sh) & mb);
  end

  assign cfg_err   = !fmt_ok;
  assign pix_ready = run && fmt_ok && !tail &&
                     ((fmt == 2'd3) ? (!have || (step == 2'd1 && !have_b)) : !have);
  assign pix_go    = pix_valid && pix_ready;
  assign hits      = (cnt + 1'b1) == tot_q;

  assign pk_valid  = have && (fmt != 2'd3 || step == 2'd0 || have_b);
  assign out_valid = run ? pk_valid : wr_valid;
  assign out_data  = run ? pk_word : wr_data;
  assign out_dc    = run ? 1'b1 : wr_flag;
  assign wr_ready  = !run && out_ready;
  assign pk_go     = run && pk_valid && out_ready;

  assign busy       = run;
  assign frame_done = done_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run    <= 1'b0;
      have   <= 1'b0;
      have_b <= 1'b0;
      tail   <= 1'b0;
      done_q <= 1'b0;
      step   <= 2'd0;
      a_q    <= '0;
      b_q    <= '0;
      cnt    <= '0;
      tot_q  <= '0;
    end else begin
      done_q <= 1'b0;
      if (!run && frame_start && frame_total != '0) begin
        run   <= 1'b1;
        cnt   <= '0;
        tot_q <= frame_total;
        tail  <= 1'b0;
      end
      if (pix_go) begin
        cnt <= cnt + 1'b1;
        if (hits) tail <= 1'b1;
        if (!have) begin
          a_q  <= pix_data;
          have <= 1'b1;
          if (fmt == 2'd3 && hits) begin
            b_q    <= '0;
            have_b <= 1'b1;
          end
        end else begin
          b_q    <= pix_data;
          have_b <= 1'b1;
        end
      end
      if (pk_go) begin
        if (step == last_step) begin
          have   <= 1'b0;
          have_b <= 1'b0;
          step   <= 2'd0;
          if (tail) begin
            run    <= 1'b0;
            tail   <= 1'b0;
            done_q <= 1'b1;
          end
        end else begin
          step <= step + 2'd1;
        end
      end
    end
  end

endmodule

// File: rtl/pix_bus_packer_chk.sv
module pix_bus_packer_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [1:0]  cfg_bus,
  input logic        cfg_err,
  input logic        pix_ready,
  input logic        busy,
  input logic        frame_done,
  input logic        out_valid,
  input logic        out_ready,
  input logic        out_dc,
  input logic [15:0] out_data
);

  AST_CFG_BLOCKS_PIX: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_err |-> !pix_ready); // R2

  AST_PIX_WORD_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && out_valid) |-> out_dc); // R3

  AST_NARROW_BUS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && out_valid && cfg_bus == 2'd0) |-> (out_data[15:8] == 8'h00)); // R3

  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |=> !frame_done); // R7

  AST_DONE_ENDS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |-> (!busy && !pix_ready)); // R7

  AST_WORD_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && out_valid && !out_ready) |=>
      (out_valid && $stable(out_data) && $stable(out_dc))); // R9

endmodule

bind pix_bus_packer pix_bus_packer_chk i_chk (
  .clk(clk), .rst_n(rst_n), .cfg_bus(cfg_bus), .cfg_err(cfg_err),
  .pix_ready(pix_ready), .busy(busy), .frame_done(frame_done),
  .out_valid(out_valid), .out_ready(out_ready), .out_dc(out_dc),
  .out_data(out_data)
);

// File: tb/test_pix_bus_packer.sv
module test_pix_bus_packer;
  localparam int CW = 22;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic [1:0]    cfg_dtype = 2'd3, cfg_bus = 2'd3;
  logic [CW-1:0] frame_total = '0;
  logic          frame_start = 1'b0;
  logic          pix_valid = 1'b0;
  logic [23:0]   pix_data = '0;
  logic          pix_ready;
  logic          wr_valid = 1'b0, wr_flag = 1'b0;
  logic [15:0]   wr_data = '0;
  logic          wr_ready, out_valid, out_dc, cfg_err, busy, frame_done;
  logic [15:0]   out_data;
  logic          out_ready = 1'b0;

  pix_bus_packer #(.CNT_W(CW)) i_pix_bus_packer (
    .clk(clk), .rst_n(rst_n), .cfg_dtype(cfg_dtype), .cfg_bus(cfg_bus),
    .frame_total(frame_total), .frame_start(frame_start),
    .pix_valid(pix_valid), .pix_data(pix_data), .pix_ready(pix_ready),
    .wr_valid(wr_valid), .wr_flag(wr_flag), .wr_data(wr_data), .wr_ready(wr_ready),
    .out_valid(out_valid), .out_data(out_data), .out_dc(out_dc), .out_ready(out_ready),
    .cfg_err(cfg_err), .busy(busy), .frame_done(frame_done)
  );

  int vecs = 0;
  int errs = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    vecs++;
    if (!ok) begin
      errs++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic int pwid(input logic [1:0] d);
    case (d) 2'd0: return 12; 2'd1: return 16; 2'd2: return 18; default: return 24; endcase
  endfunction

  function automatic int bwid(input logic [1:0] b);
    case (b) 2'd0: return 8; 2'd1: return 9; 2'd2: return 12; default: return 16; endcase
  endfunction

  function automatic int ref_fmt(input logic [1:0] d, input logic [1:0] b);
    int p = pwid(d);
    int w = bwid(b);
    if (p % w == 0 && p / w >= 1 && p / w <= 3) return p / w - 1;
    if ((2 * p) % w == 0 && (2 * p) / w == 3) return 3;
    return -1;
  endfunction

  logic [23:0] pix[$];
  logic [15:0] expq[$];

  task automatic gen_pix(input logic [1:0] d, input int n);
    pix.delete();
    for (int i = 0; i < n; i++)
      pix.push_back(24'($urandom) & ((24'h1 << pwid(d)) - 24'h1));
  endtask

  task automatic build_exp(input logic [1:0] d, input logic [1:0] b, input int n);
    bit bq[$];
    int p = pwid(d);
    int w = bwid(b);
    expq.delete();
    for (int i = 0; i < n; i++)
      for (int k = p - 1; k >= 0; k--) bq.push_back(pix[i][k]);
    if (ref_fmt(d, b) == 3 && (n % 2) == 1)
      for (int k = 0; k < p; k++) bq.push_back(1'b0);
    for (int i = 0; i + w <= bq.size(); i += w) begin
      logic [15:0] wd = '0;
      for (int k = 0; k < w; k++) wd[w-1-k] = bq[i+k];
      expq.push_back(wd);
    end
  endtask

  task automatic start(input int total);
    @(negedge clk);
    frame_total = CW'(total);
    frame_start = 1'b1;
    @(negedge clk);
    frame_start = 1'b0;
  endtask

  task automatic drain(input logic [1:0] d, input int n, input int pct, input string tag);
    int  pi = 0;
    int  wi = 0;
    bit  done = 0;
    for (int cyc = 0; cyc < 3000 && !done; cyc++) begin
      out_ready = ($urandom % 100) < pct;
      pix_valid = (pi < n) && ($urandom % 4 != 0);
      pix_data  = (pi < n) ? (pix[pi] | 24'(32'($urandom) << pwid(d))) : 24'h0;
      #3;
      if (frame_done) done = 1;
      else begin
        if (out_valid && out_ready) begin
          if (wi < expq.size())
            chk(out_data == expq[wi] && out_dc, tag, {out_dc, out_data}, {1'b1, expq[wi]});
          else
            chk(1'b0, tag, out_data, -1);
          wi++;
        end
        if (pix_valid && pix_ready) pi++;
      end
      @(negedge clk);
    end
    chk(done, "R7", done, 1);
    chk(wi == expq.size(), "R7", wi, expq.size());
    out_ready = 1'b1;
    pix_valid = 1'b0;
    #3;
    chk(!frame_done && !busy && !pix_ready, "R7", {frame_done, busy, pix_ready}, 0);
    @(negedge clk);
  endtask

  task automatic run_frame(input logic [1:0] d, input logic [1:0] b, input int n, input int pct);
    int    f;
    string tag;
    cfg_dtype = d;
    cfg_bus   = b;
    f = ref_fmt(d, b);
    tag = (f == 0) ? "R3" : (f < 3) ? "R4" : ((n % 2) == 1) ? "R6" : "R5";
    gen_pix(d, n);
    build_exp(d, b, n);
    start(n);
    drain(d, n, pct, tag);
  endtask

  initial begin
    #(8 * 150000);
    errs++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_0042));
    repeat (3) @(negedge clk);
    #3;
    chk(!out_valid && !pix_ready && !busy && !frame_done, "R1",
        {out_valid, pix_ready, busy, frame_done}, 0);
    @(negedge clk);
    rst_n = 1'b1;
    #3;
    chk(!out_valid && !pix_ready && !busy && !frame_done, "R1",
        {out_valid, pix_ready, busy, frame_done}, 0);

    for (int c = 0; c < 16; c++) begin
      @(negedge clk);
      cfg_dtype = 2'(c >> 2);
      cfg_bus   = 2'(c);
      #1;
      chk(cfg_err == (ref_fmt(cfg_dtype, cfg_bus) < 0), "R2", cfg_err,
          ref_fmt(cfg_dtype, cfg_bus) < 0);
    end

    for (int rep = 0; rep < 3; rep++)
      for (int c = 0; c < 16; c++)
        if (ref_fmt(2'(c >> 2), 2'(c)) >= 0)
          run_frame(2'(c >> 2), 2'(c), 1 + int'($urandom % 8),
                    (rep == 0) ? 100 : (rep == 1) ? 60 : 25);

    run_frame(2'd0, 2'd0, 1, 70);   // R6 single pixel paired with zero
    run_frame(2'd0, 2'd0, 3, 70);   // R6
    run_frame(2'd3, 2'd3, 5, 50);   // R6
    run_frame(2'd2, 2'd2, 6, 80);   // R5
    run_frame(2'd3, 2'd0, 4, 90);   // R4 three bytes per pixel
    run_frame(2'd1, 2'd0, 4, 90);   // R4 high byte first

    // R2: invalid width pair refuses pixels, then recovers
    cfg_dtype = 2'd1; cfg_bus = 2'd1;
    gen_pix(2'd1, 2);
    start(2);
    pix_valid = 1'b1; pix_data = 24'h00BEEF; out_ready = 1'b1;
    for (int i = 0; i < 6; i++) begin
      #3;
      chk(!pix_ready && !out_valid && cfg_err, "R2", {pix_ready, out_valid, cfg_err}, 1);
      @(negedge clk);
    end
    cfg_bus = 2'd3;
    build_exp(2'd1, 2'd3, 2);
    drain(2'd1, 2, 80, "R2");

    // R10: zero total ignored
    start(0);
    #3;
    chk(!busy, "R10", busy, 0);
    // R10: restart and total change during frame ignored
    cfg_dtype = 2'd3; cfg_bus = 2'd0;
    gen_pix(2'd3, 3);
    build_exp(2'd3, 2'd0, 3);
    start(3);
    frame_total = CW'(1);
    frame_start = 1'b1;
    @(negedge clk);
    frame_start = 1'b0;
    frame_total = CW'(7);
    drain(2'd3, 3, 70, "R10");

    // R8: pass-through while idle
    wr_valid = 1'b1; wr_flag = 1'b0; wr_data = 16'hA5C3; out_ready = 1'b1;
    #3;
    chk(out_valid && wr_ready && out_data == 16'hA5C3 && !out_dc, "R8",
        {out_valid, wr_ready, out_dc, out_data}, {1'b1, 1'b1, 1'b0, 16'hA5C3});
    @(negedge clk);
    wr_flag = 1'b1; wr_data = 16'h1234;
    #3;
    chk(out_valid && out_data == 16'h1234 && out_dc, "R8",
        {out_valid, out_dc, out_data}, {1'b1, 1'b1, 16'h1234});
    // R8: held off during a frame
    cfg_dtype = 2'd0; cfg_bus = 2'd2;
    gen_pix(2'd0, 2);
    build_exp(2'd0, 2'd2, 2);
    start(2);
    #3;
    chk(!wr_ready, "R8", wr_ready, 0);
    @(negedge clk);
    drain(2'd0, 2, 60, "R8");
    wr_valid = 1'b0;

    // R9: word held under backpressure
    cfg_dtype = 2'd3; cfg_bus = 2'd0;
    pix.delete();
    pix.push_back(24'hABCDEF);
    build_exp(2'd3, 2'd0, 1);
    start(1);
    out_ready = 1'b0; pix_valid = 1'b1; pix_data = 24'hABCDEF;
    @(negedge clk);
    pix_valid = 1'b0;
    for (int i = 0; i < 4; i++) begin
      #3;
      chk(out_valid && out_data == 16'h00AB && out_dc, "R9",
          {out_valid, out_data}, {1'b1, 16'h00AB});
      @(negedge clk);
    end
    drain(2'd3, 1, 100, "R9");

    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end

endmodule